// File: doc/BRIEF.md
# Interrupt Pending Register with Shared Source

This block holds the pending state of eight interrupt lines for a small microcontroller interrupt unit. A one-cycle request pulse on a line sets its pending bit. The bit stays set until the interrupt unit signals that it has taken the vector for that line. Software can read the register. Writing it replaces the bits, so software can raise an interrupt by writing a 1 or cancel one by writing a 0.

The top bit is shared. It collects a bank of secondary event flags, each with its own enable mask bit. An enabled flag that goes high raises the shared line. Software reads the secondary flags to find the cause and clears them by writing ones. A parameter marks some bit positions as reserved. Those positions never become pending and always read as zero.

Bit order, from bit 7 down, is: shared, channel 3, channel 2, channel 1, channel 0, converter done, serial transmit, serial receive.

Top module: `ipend_unit`

## Requirements
- R1: After reset, the pending register, the secondary mask and the secondary flags are all zero.
- R2: A request pulse on `irq_req[i]` sets pending bit i at the next clock edge. The bit stays set while no acknowledge, software write or reset reaches it.
- R3: When `ack_valid` is high, pending bit `ack_idx` clears at the next edge. The other bits are unaffected.
- R4: If a request and an acknowledge hit the same bit in the same cycle, the bit ends up set.
- R5: A write to address 0 loads the pending bits with the write data, where 1 sets and 0 clears. A hardware request in the same cycle is ORed into the written value.
- R6: Bits selected by parameter `RSVD_MASK` (default 8'h03, which reserves bits 1 and 0) never become pending, whatever the requests or writes, and they read as zero.
- R7: A pulse on `sec_evt[j]` sets secondary flag j. Writing a 1 to bit j at address 2 clears flag j, and writing a 0 leaves it unchanged. If an event and a clear hit the same flag in the same cycle, the flag ends up set. Address 1 holds the secondary mask and reads back what was written.
- R8: The shared bit 7 becomes pending one edge after the OR of (secondary flags AND mask) rises, whether the rise came from an event or from a mask write. After it is acknowledged, it does not pend again while that OR stays high.
- R9: `irq_req[7]` has no effect. Only the secondary bank can set the shared bit through hardware.
- R10: A read returns data on `cpu_rdata` one edge after `cpu_re`. Address 3 reads zero, and writes to address 3 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | 8 | Per-line interrupt request pulses |
| ack_valid | input | 1 | Vector-taken acknowledge |
| ack_idx | input | 3 | Bit index being acknowledged |
| cpu_we | input | 1 | Register write strobe |
| cpu_re | input | 1 | Register read strobe |
| cpu_addr | input | 2 | Register select: 0 pending, 1 mask, 2 secondary flags, 3 none |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Registered read data |
| sec_evt | input | 8 | Secondary event pulses |
| pend_o | output | 8 | Pending bits toward the arbiter |

## Verification
Requests, acknowledges, pending writes, secondary flag changes and mask changes appear at their outputs one edge after the cycle in which they are driven. Read data also appears one edge after the strobe. The shared bit is the exception: it needs two edges after a secondary event, because the flag must be set before its rising OR is registered into bit 7. The bench drives every input on the falling edge and samples on the next falling edge. For the shared bit, it waits one extra cycle, so each check reads a value that has settled for half a period.

// File: rtl/ipend_pkg.sv
package ipend_pkg;
  typedef enum logic [1:0] {
    SEL_MAIN  = 2'd0,
    SEL_MASK  = 2'd1,
    SEL_SPEND = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int SHARED_IDX = 7;
endpackage

// File: rtl/ipend_sec_bank.sv
module ipend_sec_bank #(
  parameter int SEC_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEC_W-1:0] evt,
  input  logic             mask_we,
  input  logic             clr_we,
  input  logic [SEC_W-1:0] wdata,
  output logic [SEC_W-1:0] flags,
  output logic [SEC_W-1:0] mask,
  output logic             any_q,
  output logic             rise
);
  logic any_now;

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      mask  <= '0;
      any_q <= 1'b0;
    end else begin
      flags <= (clr_we ? (flags & ~wdata) : flags) | evt;
      if (mask_we) mask <= wdata;
      any_q <= any_now;
    end
  end

  assign any_now = |(flags & mask);
  assign rise    = any_now & ~any_q;

  // R7
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));

  // R7
  w1c_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_we && ((wdata & evt) == '0)) |=> ((flags & $past(wdata)) == '0));
endmodule

// File: rtl/ipend_main_reg.sv
module ipend_main_reg #(
  parameter int                 NUM_BITS  = 8,
  parameter logic [NUM_BITS-1:0] RSVD_MASK = 8'h03,
  localparam int                IDX_W     = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] hw_set,
  input  logic                ack_valid,
  input  logic [IDX_W-1:0]    ack_idx,
  input  logic                sw_we,
  input  logic [NUM_BITS-1:0] sw_wdata,
  output logic [NUM_BITS-1:0] pend
);
  genvar gi;
  generate
    for (gi = 0; gi < NUM_BITS; gi++) begin : g_bit
      if (RSVD_MASK[gi]) begin : g_rsvd
        always_ff @(posedge clk) pend[gi] <= 1'b0;
      end else begin : g_live
        logic ack_hit;
        assign ack_hit = ack_valid && (ack_idx == IDX_W'(gi));
        always_ff @(posedge clk) begin
          if (rst)        pend[gi] <= 1'b0;
          else if (sw_we) pend[gi] <= sw_wdata[gi] | hw_set[gi];
          else            pend[gi] <= (pend[gi] & ~ack_hit) | hw_set[gi];
        end
      end
    end
  endgenerate

  // R2
  hw_set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    (|(hw_set & ~RSVD_MASK)) |=>
      ((pend & $past(hw_set & ~RSVD_MASK)) == $past(hw_set & ~RSVD_MASK)));

  // R3
  ack_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && !sw_we && !hw_set[ack_idx]) |=> !pend[$past(ack_idx)]);

  // R5
  sw_write_loads_chk: assert property (@(posedge clk) disable iff (rst)
    sw_we |=> (pend == (($past(sw_wdata) | $past(hw_set)) & ~RSVD_MASK)));

  // R6
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (sw_we || (|hw_set)) |=> ((pend & RSVD_MASK) == '0));
endmodule

// File: rtl/ipend_unit.sv
module ipend_unit #(
  parameter int                 NUM_BITS  = 8,
  parameter int                 SEC_W     = 8,
  parameter int                 DATA_W    = 8,
  parameter logic [NUM_BITS-1:0] RSVD_MASK = 8'h03,
  localparam int                IDX_W     = $clog2(NUM_BITS)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_BITS-1:0] irq_req,
  input  logic                ack_valid,
  input  logic [IDX_W-1:0]    ack_idx,
  input  logic                cpu_we,
  input  logic                cpu_re,
  input  logic [1:0]          cpu_addr,
  input  logic [DATA_W-1:0]   cpu_wdata,
  output logic [DATA_W-1:0]   cpu_rdata,
  input  logic [SEC_W-1:0]    sec_evt,
  output logic [NUM_BITS-1:0] pend_o
);
  import ipend_pkg::*;

  reg_sel_e            sel;
  logic [SEC_W-1:0]    sec_flags, sec_mask;
  logic                sec_any_q, sec_rise;
  logic [NUM_BITS-1:0] hw_set, sh_onehot;
  logic [DATA_W-1:0]   rd_nxt;

  assign sel = reg_sel_e'(cpu_addr);

  always_comb begin
    sh_onehot             = '0;
    sh_onehot[SHARED_IDX] = 1'b1;
    hw_set = (irq_req & ~sh_onehot) | (sec_rise ? sh_onehot : '0);
  end

  ipend_sec_bank #(.SEC_W(SEC_W)) u_sec (
    .clk     (clk),
    .rst     (rst),
    .evt     (sec_evt),
    .mask_we (cpu_we && sel == SEL_MASK),
    .clr_we  (cpu_we && sel == SEL_SPEND),
    .wdata   (cpu_wdata[SEC_W-1:0]),
    .flags   (sec_flags),
    .mask    (sec_mask),
    .any_q   (sec_any_q),
    .rise    (sec_rise)
  );

  ipend_main_reg #(.NUM_BITS(NUM_BITS), .RSVD_MASK(RSVD_MASK)) u_main (
    .clk       (clk),
    .rst       (rst),
    .hw_set    (hw_set),
    .ack_valid (ack_valid),
    .ack_idx   (ack_idx),
    .sw_we     (cpu_we && sel == SEL_MAIN),
    .sw_wdata  (cpu_wdata[NUM_BITS-1:0]),
    .pend      (pend_o)
  );

  always_comb begin
    rd_nxt = '0;
    case (sel)
      SEL_MAIN:  rd_nxt[NUM_BITS-1:0] = pend_o;
      SEL_MASK:  rd_nxt[SEC_W-1:0]    = sec_mask;
      SEL_SPEND: rd_nxt[SEC_W-1:0]    = sec_flags;
      default:   rd_nxt               = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         cpu_rdata <= '0;
    else if (cpu_re) cpu_rdata <= rd_nxt;
  end

  // R8
  shared_rise_pends_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(|(sec_flags & sec_mask)) && !cpu_we) |=> pend_o[SHARED_IDX]);

  // R8
  shared_no_repend_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && ack_idx == IDX_W'(SHARED_IDX) && sec_any_q && !cpu_we) |=>
      !pend_o[SHARED_IDX]);

  // R10
  read_none_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_re && sel == SEL_NONE) |=> (cpu_rdata == '0));
endmodule

// File: tb/ipend_unit_tb.sv
module ipend_unit_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst;
  logic [7:0] irq_req;
  logic       ack_valid;
  logic [2:0] ack_idx;
  logic       cpu_we, cpu_re;
  logic [1:0] cpu_addr;
  logic [7:0] cpu_wdata, cpu_rdata, sec_evt, pend_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipend_unit u_dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .ack_valid(ack_valid),
    .ack_idx(ack_idx), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .sec_evt(sec_evt),
    .pend_o(pend_o)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", tag, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_in();
    irq_req = '0; ack_valid = 0; ack_idx = '0; cpu_we = 0; cpu_re = 0;
    cpu_addr = '0; cpu_wdata = '0; sec_evt = '0;
  endtask

  // one edge with the given stimulus, returns on the following falling edge
  task automatic pulse(input logic [7:0] req, input logic ack, input logic [2:0] idx,
                       input logic we, input logic [1:0] addr, input logic [7:0] wd,
                       input logic [7:0] evt);
    @(negedge clk);
    irq_req = req; ack_valid = ack; ack_idx = idx; cpu_we = we;
    cpu_addr = addr; cpu_wdata = wd; sec_evt = evt;
    @(negedge clk);
    clear_in();
  endtask

  task automatic rd(input logic [1:0] addr, output logic [7:0] data);
    @(negedge clk);
    cpu_re = 1; cpu_addr = addr;
    @(negedge clk);
    data = cpu_rdata;
    clear_in();
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1 pend after reset", pend_o, 8'h00);
    rd(2'd0, d); check("R1 read pending", d, 8'h00);
    rd(2'd1, d); check("R1 read mask", d, 8'h00);
    rd(2'd2, d); check("R1 read sec flags", d, 8'h00);
  endtask

  task automatic t_hw_set();
    pulse(8'h04, 0, 0, 0, 0, 0, 0);
    check("R2 converter bit set", pend_o, 8'h04);
    idle(3);
    check("R2 bit held", pend_o, 8'h04);
    pulse(8'h03, 0, 0, 0, 0, 0, 0);
    check("R6 reserved request ignored", pend_o, 8'h04);
    pulse(8'h30, 0, 0, 0, 0, 0, 0);
    check("R2 two channels set", pend_o, 8'h34);
  endtask

  task automatic t_ack();
    pulse(8'h00, 1, 3'd4, 0, 0, 0, 0);
    check("R3 ack clears bit 4 only", pend_o, 8'h24);
  endtask

  task automatic t_set_ack_same();
    pulse(8'h20, 1, 3'd5, 0, 0, 0, 0);
    check("R4 set wins over ack", pend_o, 8'h24);
  endtask

  task automatic t_sw_write();
    logic [7:0] d;
    pulse(8'h00, 0, 0, 1, 2'd0, 8'hFF, 0);
    check("R5 R6 write ones", pend_o, 8'hFC);
    rd(2'd0, d); check("R6 read reserved zero", d, 8'hFC);
    pulse(8'h08, 0, 0, 1, 2'd0, 8'h00, 0);
    check("R5 write zero OR hw set", pend_o, 8'h08);
    pulse(8'h00, 0, 0, 1, 2'd0, 8'h00, 0);
    check("R5 write clears", pend_o, 8'h00);
  endtask

  task automatic t_shared_line();
    pulse(8'h80, 0, 0, 0, 0, 0, 0);
    idle(1);
    check("R9 irq_req[7] ignored", pend_o, 8'h00);
  endtask

  task automatic t_secondary();
    logic [7:0] d;
    pulse(8'h00, 0, 0, 0, 0, 0, 8'h01);
    idle(1);
    check("R8 masked flag no shared", pend_o, 8'h00);
    rd(2'd2, d); check("R7 flag set", d, 8'h01);
    pulse(8'h00, 0, 0, 1, 2'd1, 8'h01, 0);
    rd(2'd1, d); check("R7 mask readback", d, 8'h01);
    check("R8 mask write raises shared", pend_o, 8'h80);
    pulse(8'h00, 1, 3'd7, 0, 0, 0, 0);
    check("R3 ack shared", pend_o, 8'h00);
    idle(2);
    check("R8 no re-pend while level high", pend_o, 8'h00);
    pulse(8'h00, 0, 0, 1, 2'd2, 8'h01, 0);
    rd(2'd2, d); check("R7 w1c clears", d, 8'h00);
    pulse(8'h00, 0, 0, 0, 0, 0, 8'h01);
    idle(1);
    check("R8 new rise pends shared", pend_o, 8'h80);
    pulse(8'h00, 0, 0, 0, 0, 0, 8'h02);
    pulse(8'h00, 0, 0, 1, 2'd2, 8'h02, 8'h02);
    rd(2'd2, d); check("R7 event beats clear", d, 8'h03);
    pulse(8'h00, 0, 0, 1, 2'd2, 8'h00, 0);
    rd(2'd2, d); check("R7 write zero keeps flags", d, 8'h03);
  endtask

  task automatic t_addr3();
    logic [7:0] d;
    pulse(8'h00, 0, 0, 1, 2'd3, 8'hFF, 0);
    rd(2'd3, d); check("R10 addr3 reads zero", d, 8'h00);
    rd(2'd1, d); check("R10 addr3 write no mask change", d, 8'h01);
    rd(2'd2, d); check("R10 addr3 write no flag change", d, 8'h03);
    check("R10 addr3 write no pend change", pend_o, 8'h80);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none
  end

  initial begin
    clear_in();
    rst = 1;
    idle(3);
    rst = 0;
    t_reset();
    t_hw_set();
    t_ack();
    t_set_ack_same();
    t_sw_write();
    t_shared_line();
    t_secondary();
    t_addr3();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule